// File: doc/BRIEF.md
# Scanline IRQ counter

This block sits on the cartridge side of a video game console and raises an interrupt to the CPU after a programmed number of rendered scanlines. It holds an 8-bit reload latch, an 8-bit down-counter, a deferred-reload flag and an enable bit. The CPU programs it through writes into the upper half of its address space. A dedicated strobe loads the latch, and separate strobes acknowledge the request or disable the interrupt.

The counter advances once per counting clock. A counting clock comes from one of two sources. The first is the video side's dot position, qualified so that there is one clock per visible line while rendering is on. The second is a CPU write to the video address register. A reload request from the CPU does not touch the counter at once. It is held until the next counting clock. When the latch holds zero and the interrupt is enabled, every counting clock raises the request.

Top module: `scanirq_top`

## Requirements
- R1: On reset the counter, latch, deferred-reload flag, enable bit and `irq_out` are all zero. The same holds after a reset applied while a request is pending.
- R2: A CPU write of any data with `cpu_addr[15:13]` = 3'b110 leaves the counter unchanged and only sets the deferred-reload flag. On the next counting clock the counter takes the latch value, and the same clock then applies R5/R6 to that value. With a latch of 1 this means the counter reaches zero and raises the request.
- R3: A CPU write with `cpu_addr[15:13]` = 3'b111 sets the enable bit.
- R4: `latch_wr` loads the latch from `cpu_data` without changing the counter.
- R5: On a counting clock that sees a zero counter, the counter is reloaded from the latch and no request is raised, unless R7 applies.
- R6: On any other counting clock the counter decrements by one. If it reaches zero while enabled, `irq_out` rises in the next cycle.
- R7: On a counting clock with a zero latch and the enable bit set, the counter is set to zero and the request is raised.
- R8: `irq_out` stays high until `irq_ack`. A request raised in the same cycle as `irq_ack` wins, so `irq_out` stays high.
- R9: `irq_disable` clears both the enable bit and `irq_out`, and takes priority over every other event in the same cycle.
- R10: A video counting clock occurs only when all of these hold in one cycle: `vid_stb` is high, `vid_render` is high, `vid_dot` = 260, and `vid_line` is between 1 and 240 inclusive.
- R11: `vaddr_wr` produces one counting clock. If it coincides with a video counting clock, only one clock results.
- R12: CPU writes with `cpu_addr[15:14]` other than 2'b11 leave all counter state unchanged. So does any cycle with `cpu_wr` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data, also the latch source |
| cpu_wr | input | 1 | CPU write strobe |
| latch_wr | input | 1 | Load latch from `cpu_data` |
| irq_disable | input | 1 | Clear enable bit and request |
| irq_ack | input | 1 | Clear request |
| vid_stb | input | 1 | One-cycle pulse when the video dot position advances |
| vid_render | input | 1 | Rendering is on |
| vid_dot | input | 9 | Current dot within the line |
| vid_line | input | 9 | Current line |
| vaddr_wr | input | 1 | CPU write to the video address register |
| irq_out | output | 1 | Level interrupt request |

## Verification
Some rules are checked on every cycle by assertions. The counter holds still between counting clocks, whatever the CPU writes. A zero counter reloads from the latch, and any other counter decrements. The request rises only on a counting clock, and it holds until acknowledged or disabled. Writes outside the decoded range leave the latch, flag and enable unchanged.

Some behaviour only the bench scenarios can show, because it needs the request timing across many clocks. These cases are:
- the deferred reload landing one clock late;
- rejection of video ticks at the wrong dot or line, or with rendering off;
- coincident tick sources merging into one clock;
- a zero latch firing on every clock;
- re-enabling after a disable.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 16;
    localparam int POS_W  = 9;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RELOAD,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        cnt_t count;
        logic fire;
    } step_t;

    // Top three address bits select the register (R2, R3, R12)
    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr, input logic wr);
        logic [2:0] top;
        top = addr[ADDR_W-1 -: 3];
        if (!wr)               return SEL_NONE;
        else if (top == 3'b110) return SEL_RELOAD;
        else if (top == 3'b111) return SEL_ENABLE;
        else                    return SEL_NONE;
    endfunction

    // One counting clock: deferred reload, zero-latch fire, reload-or-decrement
    function automatic step_t count_step(input cnt_t cur, input cnt_t lat,
                                         input logic pend, input logic en);
        cnt_t  base;
        step_t r;
        base   = pend ? lat : cur;
        r.fire = 1'b0;
        if (lat == '0 && en) begin
            r.fire = 1'b1;
            base   = '0;
        end
        if (base == '0) begin
            r.count = lat;
        end else begin
            r.count = base - cnt_t'(1);
            if (r.count == '0 && en) r.fire = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/scanirq_tick_gen.sv
module scanirq_tick_gen
    import scanirq_pkg::*;
#(
    parameter int TICK_DOT   = 260,
    parameter int FIRST_LINE = 1,
    parameter int LAST_LINE  = 240
) (
    input  logic             vid_stb,
    input  logic             vid_render,
    input  logic [POS_W-1:0] vid_dot,
    input  logic [POS_W-1:0] vid_line,
    input  logic             vaddr_wr,
    output logic             tick
);
    localparam logic [POS_W-1:0] DOT_V   = POS_W'(TICK_DOT);
    localparam logic [POS_W-1:0] LINE_LO = POS_W'(FIRST_LINE);
    localparam logic [POS_W-1:0] LINE_HI = POS_W'(LAST_LINE);

    logic in_window;
    logic video_tick;

    // R10: one qualified point per visible line while rendering
    assign in_window  = (vid_dot == DOT_V) && (vid_line >= LINE_LO) && (vid_line <= LINE_HI);
    assign video_tick = vid_stb && vid_render && in_window;
    // R11: the two sources merge into a single clock
    assign tick       = video_tick || vaddr_wr;
endmodule

// File: rtl/scanirq_regs.sv
module scanirq_regs
    import scanirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CNT_W-1:0]  cpu_data,
    input  logic              cpu_wr,
    input  logic              latch_wr,
    input  logic              irq_disable,
    input  logic              tick,
    output cnt_t              latch,
    output logic              pend,
    output logic              en
);
    reg_sel_e sel;
    assign sel = decode_sel(cpu_addr, cpu_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
            pend  <= 1'b0;
            en    <= 1'b0;
        end else begin
            if (latch_wr) latch <= cpu_data;             // R4
            if (sel == SEL_RELOAD) pend <= 1'b1;         // R2
            else if (tick)         pend <= 1'b0;
            if (irq_disable)            en <= 1'b0;      // R9
            else if (sel == SEL_ENABLE) en <= 1'b1;      // R3
        end
    end

    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[ADDR_W-1 -: 2] != 2'b11 && !latch_wr && !irq_disable && !tick)
        |=> ($stable(pend) && $stable(en) && $stable(latch))); // R12

    AST_DISABLE_EN: assert property (@(posedge clk) disable iff (rst)
        irq_disable |=> !en); // R9
endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter
    import scanirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  cnt_t latch,
    input  logic pend,
    input  logic en,
    input  logic irq_ack,
    input  logic irq_disable,
    output logic irq_out
);
    cnt_t  cnt;
    step_t nxt;

    assign nxt = count_step(cnt, latch, pend, en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            irq_out <= 1'b0;
        end else begin
            if (tick) cnt <= nxt.count;
            if (irq_disable)            irq_out <= 1'b0; // R9
            else if (tick && nxt.fire)  irq_out <= 1'b1; // R6, R7
            else if (irq_ack)           irq_out <= 1'b0; // R8
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !irq_out)); // R1

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R2

    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend && cnt == '0) |=> cnt == $past(latch)); // R5

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend && cnt != '0 && !(latch == '0 && en))
        |=> cnt == $past(cnt) - cnt_t'(1)); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!irq_out && !tick) |=> !irq_out); // R6

    AST_ZERO_LATCH_FIRE: assert property (@(posedge clk) disable iff (rst)
        (tick && latch == '0 && en && !irq_disable) |=> irq_out); // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !irq_ack && !irq_disable) |=> irq_out); // R8

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !tick && !irq_disable) |=> !irq_out); // R8

    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq_disable |=> !irq_out); // R9
endmodule

// File: rtl/scanirq_top.sv
module scanirq_top
    import scanirq_pkg::*;
#(
    parameter int TICK_DOT   = 260,
    parameter int FIRST_LINE = 1,
    parameter int LAST_LINE  = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CNT_W-1:0]  cpu_data,
    input  logic              cpu_wr,
    input  logic              latch_wr,
    input  logic              irq_disable,
    input  logic              irq_ack,
    input  logic              vid_stb,
    input  logic              vid_render,
    input  logic [POS_W-1:0]  vid_dot,
    input  logic [POS_W-1:0]  vid_line,
    input  logic              vaddr_wr,
    output logic              irq_out
);
    logic tick;
    cnt_t latch;
    logic pend;
    logic en;

    scanirq_tick_gen #(
        .TICK_DOT  (TICK_DOT),
        .FIRST_LINE(FIRST_LINE),
        .LAST_LINE (LAST_LINE)
    ) u_tick (
        .vid_stb   (vid_stb),
        .vid_render(vid_render),
        .vid_dot   (vid_dot),
        .vid_line  (vid_line),
        .vaddr_wr  (vaddr_wr),
        .tick      (tick)
    );

    scanirq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_data   (cpu_data),
        .cpu_wr     (cpu_wr),
        .latch_wr   (latch_wr),
        .irq_disable(irq_disable),
        .tick       (tick),
        .latch      (latch),
        .pend       (pend),
        .en         (en)
    );

    scanirq_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .latch      (latch),
        .pend       (pend),
        .en         (en),
        .irq_ack    (irq_ack),
        .irq_disable(irq_disable),
        .irq_out    (irq_out)
    );
endmodule

// File: tb/tb_scanirq_top.sv
module tb_scanirq_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr, latch_wr, irq_disable, irq_ack;
    logic        vid_stb, vid_render;
    logic [8:0]  vid_dot, vid_line;
    logic        vaddr_wr;
    logic        irq_out;

    always #4 clk = ~clk;   // 125 MHz

    scanirq_top dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .latch_wr(latch_wr), .irq_disable(irq_disable),
        .irq_ack(irq_ack), .vid_stb(vid_stb), .vid_render(vid_render),
        .vid_dot(vid_dot), .vid_line(vid_line), .vaddr_wr(vaddr_wr),
        .irq_out(irq_out)
    );

    typedef struct {
        logic  irq;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference state, built from the requirements
    logic [7:0] m_cnt = 0, m_lat = 0;
    logic       m_pend = 0, m_en = 0, m_irq = 0;

    // scoreboard monitor: one expected item per clock
    initial forever begin
        exp_t e;
        @(posedge clk);
        #1;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (irq_out !== e.irq) begin
                errors++;
                $display("FAIL %s: irq_out=%0b expected %0b at %0t", e.tag, irq_out, e.irq, $time);
            end
        end
    end

    task automatic model_step(input string tag);
        logic       tick, fire;
        logic [7:0] base;
        exp_t       e;
        tick = (vid_stb && vid_render && vid_dot == 9'd260 &&
                vid_line >= 9'd1 && vid_line <= 9'd240) || vaddr_wr;   // R10, R11
        if (rst) begin
            m_cnt = 0; m_lat = 0; m_pend = 0; m_en = 0; m_irq = 0;      // R1
        end else begin
            fire = 1'b0;
            if (tick) begin
                base   = m_pend ? m_lat : m_cnt;                      // R2
                m_pend = 1'b0;
                if (m_lat == 0 && m_en) begin fire = 1'b1; base = 0; end // R7
                if (base == 0) m_cnt = m_lat;                         // R5
                else begin
                    m_cnt = base - 8'd1;                              // R6
                    if (m_cnt == 0 && m_en) fire = 1'b1;
                end
            end
            if (cpu_wr && cpu_addr[15:13] == 3'b110) m_pend = 1'b1;
            if (cpu_wr && cpu_addr[15:13] == 3'b111) m_en = 1'b1;     // R3
            if (latch_wr) m_lat = cpu_data;                           // R4
            if (irq_ack) m_irq = 1'b0;                                // R8
            if (fire)    m_irq = 1'b1;
            if (irq_disable) begin m_en = 1'b0; m_irq = 1'b0; end     // R9
        end
        e.irq = m_irq;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    // driver: inputs already set; push expectation, advance one clock, drop strobes
    task automatic cyc(input string tag);
        model_step(tag);
        @(negedge clk);
        cpu_wr = 0; latch_wr = 0; irq_disable = 0; irq_ack = 0;
        vid_stb = 0; vaddr_wr = 0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        cpu_addr = a; cpu_data = d; cpu_wr = 1; cyc(tag);
    endtask

    task automatic set_latch(input logic [7:0] v, input string tag);
        cpu_data = v; latch_wr = 1; cyc(tag);
    endtask

    task automatic vtick(input logic r, input int dot, input int line, input string tag);
        vid_stb = 1; vid_render = r; vid_dot = 9'(dot); vid_line = 9'(line); cyc(tag);
    endtask

    task automatic atick(input string tag);
        vaddr_wr = 1; cyc(tag);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; cpu_addr = 0; cpu_data = 0; cpu_wr = 0; latch_wr = 0;
        irq_disable = 0; irq_ack = 0; vid_stb = 0; vid_render = 0;
        vid_dot = 0; vid_line = 0; vaddr_wr = 0;
        @(negedge clk);
        idle(2, "R1 reset");
        rst = 0;
        idle(2, "R1 idle after reset");

        // deferred reload: latch 3, enable, reload request
        set_latch(8'd3, "R4 latch load");
        cpu_write(16'hE000, 8'h00, "R3 enable");
        cpu_write(16'hC000, 8'hAB, "R2 reload request");
        idle(2, "R2 no direct change");
        atick("R11 address-write clock");      // 3 -> 2
        vtick(1, 260, 1, "R10 first line");    // 2 -> 1
        vtick(0, 260, 5, "R10 rendering off");
        vtick(1, 259, 5, "R10 wrong dot");
        vtick(1, 260, 0, "R10 line 0");
        vtick(1, 260, 241, "R10 line 241");
        vid_dot = 9'd260; vid_line = 9'd7; vid_render = 1;
        idle(2, "R10 no strobe");
        vtick(1, 260, 240, "R6 reach zero fires");
        idle(3, "R8 request held");
        irq_ack = 1; cyc("R8 ack clears");
        idle(1, "R8 stays low");

        // zero counter reloads without firing
        vtick(1, 260, 100, "R5 zero reload no irq");  // 0 -> 3
        vtick(1, 260, 101, "R6 decrement");           // 2
        vtick(1, 260, 102, "R6 decrement");           // 1
        cpu_write(16'h8000, 8'h55, "R12 low bank write");
        cpu_write(16'hA001, 8'h01, "R12 protect range write");
        cpu_write(16'h6000, 8'hFF, "R12 ram range write");
        cpu_write(16'hBFFF, 8'h00, "R12 edge below range");
        cpu_addr = 16'hC000; idle(1, "R12 no strobe");
        cpu_addr = 16'hE000; idle(1, "R12 no strobe");
        vtick(1, 260, 103, "R12 timing unchanged fires");  // 1 -> 0
        irq_ack = 1; cyc("R8 ack");

        // fire and ack in the same cycle
        set_latch(8'd1, "R4 latch 1");
        atick("R5 reload to 1");               // 0 -> 1
        irq_ack = 1; atick("R8 fire wins over ack");  // 1 -> 0 fire
        idle(1, "R8 held");
        irq_ack = 1; cyc("R8 ack");

        // coincident sources count once
        vaddr_wr = 1; vtick(1, 260, 50, "R11 merged clock");  // 0 -> 1 only
        idle(1, "R11 no double count");
        atick("R11 next clock fires");                       // 1 -> 0
        irq_ack = 1; cyc("R8 ack");

        // zero latch fires on every clock
        set_latch(8'd0, "R7 latch zero");
        atick("R7 fire 1");
        irq_ack = 1; cyc("R7 ack");
        vtick(1, 260, 60, "R7 fire 2");
        irq_ack = 1; vtick(1, 260, 61, "R7 fire with ack");
        cpu_write(16'hD123, 8'h7E, "R2 reload with zero latch");
        atick("R7 fire after reload");

        // disable
        irq_disable = 1; cyc("R9 disable clears");
        atick("R9 no fire when disabled");
        irq_disable = 1; cpu_addr = 16'hFFFF; cpu_wr = 1; cyc("R9 disable beats enable");
        atick("R9 still disabled");
        cpu_write(16'hF000, 8'h00, "R3 re-enable");
        atick("R3 fires again");
        irq_disable = 1; vaddr_wr = 1; cyc("R9 disable beats fire");

        // deferred reload with latch 1 reaches zero on the same clock
        set_latch(8'd1, "R4 latch 1");
        cpu_write(16'hE000, 8'h00, "R3 enable");
        cpu_write(16'hC000, 8'h00, "R2 reload request");
        atick("R2 reload then zero fires");
        idle(1, "R8 held");

        // reset while request pending
        rst = 1; cyc("R1 reset clears request");
        rst = 0;
        atick("R1 latch and enable cleared");
        idle(2, "R1 quiet");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule